// File: doc/BRIEF.md
# Master-Slave Oscillator Phase-Reset Synchroniser

This block lines up a numerically controlled oscillator phase reset across several converter devices. Every device carries one instance. A mode input makes one instance the master, and the rest are slaves. The master drives a shared sync pin and the slaves listen to it. Each instance watches one selectable timing event: a rising edge of the SYSREF pulse, a rising edge of the multiframe-boundary signal, or a falling edge of that signal.

Software arms the receive path and the transmit path separately. For each path it drives the arm bit low and then high. On the first selected event after arming, the master raises its sync pin. On the next selected event, the master and all slaves emit a one-cycle oscillator reset strobe on the same edge, each on the paths it has armed. The master drops its pin on that same edge. After the strobe a done flag stays high, and every later event is ignored until the next arm toggle.

A slave does not count trigger edges of its own. It fires at the first selected event at which its synchronised copy of the pin is high. This keeps a slave on the same edge as the master, whatever the synchroniser latency, provided the events are further apart than that latency.

Top module: `nco_sync_top`

## Requirements
- R1: `trig_sel_i` picks the trigger event. 0 is a rising edge of `sysref_i`, 1 is a rising edge of `boundary_i` and 2 is a falling edge of `boundary_i`. Each is detected in the cycle in which the input first shows its new level. Code 3 selects no event. Events of a kind that is not selected have no effect.
- R2: A path is armed by a low-then-high sequence on its arm input (`rx_arm_i` or `tx_arm_i`). An arm input that is held high since reset arms nothing.
- R3: An armed master sets `sync_out_o` on the clock edge of the first selected event after arming.
- R4: `sync_oe_o` equals `master_mode_i`. In the cycle after any cycle in slave mode, `sync_out_o` is low.
- R5: A master whose pin is high issues its reset strobe on the clock edge of the next selected event, and `sync_out_o` falls on that same edge.
- R6: `sync_in_i` passes through a two-flop synchroniser. An armed slave issues its strobe on the clock edge of the first selected event at which the synchronised input is high. Events that arrive while it is low leave the slave armed and silent. A master and slave that are chained through the pin therefore strobe in the same cycle.
- R7: Each reset strobe (`nco_rst_rx_o`, `nco_rst_tx_o`) is high for exactly one cycle. It appears only on paths that were armed.
- R8: After the strobe, further selected events produce no strobe and no sync-out until the block is re-armed.
- R9: `done_o` goes high in the cycle in which the strobe is presented and stays high. A new arm event clears it on the next edge.
- R10: While reset is asserted and right after it, `sync_out_o`, both strobes and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Converter-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| master_mode_i | input | 1 | 1 = master, 0 = slave |
| trig_sel_i | input | 2 | Trigger event select (see R1) |
| sysref_i | input | 1 | SYSREF pulse, synchronous to clk_i |
| boundary_i | input | 1 | Multiframe boundary level, synchronous to clk_i |
| rx_arm_i | input | 1 | Receive-path arm bit |
| tx_arm_i | input | 1 | Transmit-path arm bit |
| sync_in_i | input | 1 | Shared sync pin, as seen by a slave |
| sync_out_o | output | 1 | Sync pin drive, high between the master's two events |
| sync_oe_o | output | 1 | Sync pin output enable |
| nco_rst_rx_o | output | 1 | Receive oscillator phase-reset strobe |
| nco_rst_tx_o | output | 1 | Transmit oscillator phase-reset strobe |
| done_o | output | 1 | Sequence completed since the last arm |

## Verification
The embedded properties check on every cycle that a strobe is a single cycle wide and follows an armed path. They also check that sync-out rises only on a trigger and falls only with a completed sequence, that a finished block stays finished and quiet until an arm event, and that a slave whose synchronised input is low stays armed. Other behaviour can only be shown by scenarios. These cover the choice of event kind against noise from the other kinds, the rule that an arm held high through reset does nothing, and the same-cycle strobe of a master and a slave chained through the pin. They also cover per-path gating over several arm patterns and a slave that never sees the pin.

// File: rtl/nco_sync_pkg.sv
package nco_sync_pkg;

  typedef enum logic [1:0] {
    TRIG_SYSREF   = 2'd0,
    TRIG_BND_RISE = 2'd1,
    TRIG_BND_FALL = 2'd2,
    TRIG_NONE     = 2'd3
  } trig_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PEND  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam int unsigned NUM_PATHS = 2;
  localparam int unsigned PATH_RX   = 0;
  localparam int unsigned PATH_TX   = 1;

  // Edge qualification from the current and previous input levels.
  function automatic logic trig_hit(input trig_sel_e sel,
                                    input logic sr_now, input logic sr_prev,
                                    input logic bd_now, input logic bd_prev);
    logic hit;
    case (sel)
      TRIG_SYSREF:   hit = sr_now & ~sr_prev;
      TRIG_BND_RISE: hit = bd_now & ~bd_prev;
      TRIG_BND_FALL: hit = ~bd_now & bd_prev;
      default:       hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/nco_sync_trig.sv
module nco_sync_trig
  import nco_sync_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       sysref_i,
  input  logic       bnd_i,
  output logic       trig_o
);

  logic sr_prev_q, bd_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_prev_q <= 1'b0;
      bd_prev_q <= 1'b0;
    end else begin
      sr_prev_q <= sysref_i;
      bd_prev_q <= bnd_i;
    end
  end

  assign trig_o = trig_hit(trig_sel_e'(sel_i), sysref_i, sr_prev_q, bnd_i, bd_prev_q);

  // R1
  trig_none_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == TRIG_NONE) |-> !trig_o);

endmodule

// File: rtl/nco_sync_arm.sv
module nco_sync_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic evt_o
);

  // Reset high: a level already high at reset release is not an arm event.
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= arm_i;
  end

  assign evt_o = arm_i & ~prev_q;

endmodule

// File: rtl/nco_sync_cdc.sv
module nco_sync_cdc #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/nco_sync_seq.sv
module nco_sync_seq
  import nco_sync_pkg::*;
#(
  parameter int unsigned NP = NUM_PATHS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          master_i,
  input  logic          trig_i,
  input  logic          sync_seen_i,
  input  logic [NP-1:0] arm_evt_i,
  output logic          sync_out_o,
  output logic [NP-1:0] nco_rst_o,
  output logic          done_o
);

  seq_state_e    state_q, state_d;
  logic [NP-1:0] armed_q, armed_d, pulse_q, pulse_d;
  logic          sync_q, sync_d, done_q, done_d;

  // Named internal events.
  logic any_evt, launch, fire;

  assign any_evt = |arm_evt_i;
  assign launch  = master_i && trig_i && (state_q == ST_ARMED);
  assign fire    = trig_i && (master_i ? (state_q == ST_PEND)
                                       : ((state_q == ST_ARMED) && sync_seen_i));

  always_comb begin
    state_d = state_q;
    armed_d = armed_q | arm_evt_i;
    pulse_d = '0;
    sync_d  = master_i ? sync_q : 1'b0;
    done_d  = any_evt ? 1'b0 : done_q;
    case (state_q)
      ST_IDLE, ST_DONE: if (any_evt) state_d = ST_ARMED;
      ST_ARMED: if (launch) begin
        state_d = ST_PEND;
        sync_d  = 1'b1;
      end
      default: ;
    endcase
    if (fire) begin
      state_d = ST_DONE;
      pulse_d = armed_q;
      armed_d = '0;
      sync_d  = 1'b0;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= '0;
      pulse_q <= '0;
      sync_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      pulse_q <= pulse_d;
      sync_q  <= sync_d;
      done_q  <= done_d;
    end
  end

  assign sync_out_o = sync_q;
  assign nco_rst_o  = pulse_q;
  assign done_o     = done_q;

  // R7
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse_q) |=> (pulse_q == '0));

  // R7
  pulse_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pulse_q) |-> ((pulse_q & ~$past(armed_q)) == '0));

  // R3
  sync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_q) |-> $past(trig_i));

  // R5
  sync_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sync_q) && master_i) |-> done_q);

  // R8
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !any_evt) |=> (done_q && !sync_q && (pulse_q == '0)));

  // R6
  slave_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!master_i && (state_q == ST_ARMED) && trig_i && !sync_seen_i) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/nco_sync_top.sv
module nco_sync_top
  import nco_sync_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       master_mode_i,
  input  logic [1:0] trig_sel_i,
  input  logic       sysref_i,
  input  logic       boundary_i,
  input  logic       rx_arm_i,
  input  logic       tx_arm_i,
  input  logic       sync_in_i,
  output logic       sync_out_o,
  output logic       sync_oe_o,
  output logic       nco_rst_rx_o,
  output logic       nco_rst_tx_o,
  output logic       done_o
);

  logic                 trig;
  logic                 sync_seen;
  logic [NUM_PATHS-1:0] arm_lvl, arm_evt, nco_rst;

  assign arm_lvl[PATH_RX] = rx_arm_i;
  assign arm_lvl[PATH_TX] = tx_arm_i;

  nco_sync_trig u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (trig_sel_i),
    .sysref_i (sysref_i),
    .bnd_i    (boundary_i),
    .trig_o   (trig)
  );

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_arm
    nco_sync_arm u_arm (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .arm_i  (arm_lvl[p]),
      .evt_o  (arm_evt[p])
    );
  end

  nco_sync_cdc #(.STAGES(SYNC_STAGES)) u_cdc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_in_i),
    .q_o    (sync_seen)
  );

  nco_sync_seq #(.NP(NUM_PATHS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .master_i    (master_mode_i),
    .trig_i      (trig),
    .sync_seen_i (sync_seen),
    .arm_evt_i   (arm_evt),
    .sync_out_o  (sync_out_o),
    .nco_rst_o   (nco_rst),
    .done_o      (done_o)
  );

  assign sync_oe_o    = master_mode_i;
  assign nco_rst_rx_o = nco_rst[PATH_RX];
  assign nco_rst_tx_o = nco_rst[PATH_TX];

  // R4
  slave_pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_mode_i |=> !sync_out_o);

endmodule

// File: tb/nco_sync_top_tb.sv
module nco_sync_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       sysref = 1'b0, bnd = 1'b0;
  logic       m_rx = 1'b0, m_tx = 1'b0, s_rx = 1'b0, s_tx = 1'b0;
  logic       m_sync, m_oe, m_rrx, m_rtx, m_done;
  logic       s_sync, s_oe, s_rrx, s_rtx, s_done;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nco_sync_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .master_mode_i(1'b1), .trig_sel_i(sel),
    .sysref_i(sysref), .boundary_i(bnd), .rx_arm_i(m_rx), .tx_arm_i(m_tx),
    .sync_in_i(1'b0), .sync_out_o(m_sync), .sync_oe_o(m_oe),
    .nco_rst_rx_o(m_rrx), .nco_rst_tx_o(m_rtx), .done_o(m_done)
  );

  nco_sync_top u_slv (
    .clk_i(clk), .rst_ni(rst_n), .master_mode_i(1'b0), .trig_sel_i(sel),
    .sysref_i(sysref), .boundary_i(bnd), .rx_arm_i(s_rx), .tx_arm_i(s_tx),
    .sync_in_i(m_sync), .sync_out_o(s_sync), .sync_oe_o(s_oe),
    .nco_rst_rx_o(s_rrx), .nco_rst_tx_o(s_rtx), .done_o(s_done)
  );

  // Strobe monitor, sampled away from the active edge.
  int cyc = 0, width_err = 0;
  int m_rx_n = 0, m_tx_n = 0, s_rx_n = 0, s_tx_n = 0;
  int m_rx_at = -1, m_tx_at = -1, s_rx_at = -1, s_tx_at = -1;
  logic [3:0] prev_p = 4'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (m_rrx) begin m_rx_n++; m_rx_at = cyc; end
    if (m_rtx) begin m_tx_n++; m_tx_at = cyc; end
    if (s_rrx) begin s_rx_n++; s_rx_at = cyc; end
    if (s_rtx) begin s_tx_n++; s_tx_at = cyc; end
    if (|({m_rrx, m_rtx, s_rrx, s_rtx} & prev_p)) width_err++;
    prev_p = {m_rrx, m_rtx, s_rrx, s_rtx};
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Low-then-high on the selected arm bits.
  task automatic arm(input logic mr, input logic mt, input logic sr, input logic st);
    if (mr) m_rx = 1'b0;
    if (mt) m_tx = 1'b0;
    if (sr) s_rx = 1'b0;
    if (st) s_tx = 1'b0;
    @(negedge clk);
    if (mr) m_rx = 1'b1;
    if (mt) m_tx = 1'b1;
    if (sr) s_rx = 1'b1;
    if (st) s_tx = 1'b1;
    @(negedge clk);
  endtask

  // One event of the given kind, then a quiet gap longer than the synchroniser.
  task automatic fire(input logic [1:0] k);
    case (k)
      2'd0: begin sysref = 1'b1; @(negedge clk); sysref = 1'b0; end
      2'd1: begin
        if (bnd) begin bnd = 1'b0; @(negedge clk); end
        bnd = 1'b1;
      end
      default: begin
        if (!bnd) begin bnd = 1'b1; @(negedge clk); end
        bnd = 1'b0;
      end
    endcase
    repeat (6) @(negedge clk);
  endtask

  // Events of kinds other than the selected one.
  task automatic noise(input logic [1:0] k);
    if (k != 2'd0) begin sysref = 1'b1; @(negedge clk); sysref = 1'b0; end
    if (k == 2'd1 && bnd)  bnd = 1'b0;
    if (k == 2'd2 && !bnd) bnd = 1'b1;
    if (k == 2'd0)         bnd = ~bnd;
    repeat (6) @(negedge clk);
  endtask

  // {sel[1:0], rx, tx}
  localparam logic [3:0] VEC [6] = '{4'b0011, 4'b0110, 4'b1001, 4'b0001, 4'b0111, 4'b1010};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    // Arm bits held high through reset: must not arm (R2).
    m_rx = 1'b1; s_rx = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 sync_out in reset", m_sync, 0);
    check("R10 strobes in reset", m_rrx | m_rtx | s_rrx | s_rtx, 0);
    check("R10 done in reset", m_done | s_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 done after reset", m_done | s_done, 0);
    check("R4 master output enable", m_oe, 1);
    check("R4 slave output enable", s_oe, 0);

    sel = 2'd0;
    fire(2'd0);
    check("R2 held-high arm leaves sync_out low", m_sync, 0);
    fire(2'd0);
    check("R2 held-high arm gives no strobe", m_rx_n + s_rx_n, 0);

    for (int i = 0; i < 6; i++) begin
      logic [1:0] vs;
      logic vr, vt;
      int b_mrx, b_mtx, b_srx, b_stx;
      vs = VEC[i][3:2]; vr = VEC[i][1]; vt = VEC[i][0];
      sel = vs;
      @(negedge clk);
      arm(vr, vt, vr, vt);
      check("R9 master done cleared by arm", m_done, 0);
      check("R9 slave done cleared by arm", s_done, 0);
      noise(vs);
      check("R1 unselected events ignored", m_sync, 0);
      b_mrx = m_rx_n; b_mtx = m_tx_n; b_srx = s_rx_n; b_stx = s_tx_n;
      fire(vs);
      check("R3 master sync_out after first event", m_sync, 1);
      check("R4 slave pin stays low", s_sync, 0);
      check("R6 slave silent after first event", (s_rx_n - b_srx) + (s_tx_n - b_stx), 0);
      fire(vs);
      check("R5 R7 master rx strobe count", m_rx_n - b_mrx, vr);
      check("R5 R7 master tx strobe count", m_tx_n - b_mtx, vt);
      check("R6 R7 slave rx strobe count", s_rx_n - b_srx, vr);
      check("R6 R7 slave tx strobe count", s_tx_n - b_stx, vt);
      if (vr) check("R6 rx strobes in same cycle", s_rx_at, m_rx_at);
      if (vt) check("R6 tx strobes in same cycle", s_tx_at, m_tx_at);
      check("R5 sync_out dropped with strobe", m_sync, 0);
      check("R9 done after strobe", m_done & s_done, 1);
      b_mrx = m_rx_n + m_tx_n + s_rx_n + s_tx_n;
      fire(vs);
      check("R8 later event gives no strobe", m_rx_n + m_tx_n + s_rx_n + s_tx_n, b_mrx);
      check("R8 later event gives no sync_out", m_sync, 0);
      check("R9 done held", m_done & s_done, 1);
    end

    // Slave armed while master idle: pin never rises (R6).
    sel = 2'd0;
    @(negedge clk);
    arm(1'b0, 1'b0, 1'b1, 1'b1);
    begin
      int b;
      b = s_rx_n + s_tx_n;
      fire(2'd0);
      fire(2'd0);
      check("R6 slave without pin gives no strobe", s_rx_n + s_tx_n, b);
      check("R6 slave without pin not done", s_done, 0);
    end

    // Selection code 3 never triggers (R1).
    sel = 2'd3;
    @(negedge clk);
    arm(1'b1, 1'b0, 1'b0, 1'b0);
    fire(2'd0);
    fire(2'd1);
    fire(2'd2);
    check("R1 code 3 gives no sync_out", m_sync, 0);
    check("R1 code 3 leaves master not done", m_done, 0);

    check("R7 every strobe one cycle wide", width_err, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule